// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block is the digital feedback divider of an integer-N frequency synthesizer. It steers a dual-modulus prescaler, which divides the oscillator by either 32 or 33, and it does so with two nested down-counters. The main counter sets how many prescaler periods make up one output cycle. The swallow counter sets how many of those periods use the longer ratio of 33. As a result, each divided output cycle covers exactly N = 32·M + A oscillator ticks, which is the same as A·33 + (M−A)·32. For example, M = 937 and A = 16 give N = 30000. To choose settings for a target N, take M as the integer part of N/32 and A as the remainder.

A second counter divides the crystal clock by R to produce the comparison frequency. Both counters emit a pulse one clock wide toward the phase detector at every terminal count. New M, A and R values are accepted in one write strobe. They are checked for consistency and held in shadow registers. They reach the running counters only at the next terminal count, so a cycle already under way always finishes with the ratio it started with.

The block runs on one clock, which is the oscillator-rate input tick. The prescaler period boundary and the crystal edge each arrive as a one-cycle enable.

Top module: `pswallow_divider`

## Requirements
- R1: The clock cycles between consecutive `fb_pulse` assertions equal 32·M + A for the active (M, A), given that `pre_tick` marks the end of each prescaler period and each period lasts 33 ticks when `mod_sel` was high at its start and 32 ticks otherwise.
- R2: In each output cycle, `mod_sel` is high during the first A prescaler periods and low during the remaining M−A periods. When A = 0 it is never high, and when A = M it is high for every period.
- R3: `fb_pulse` is high for exactly one clock, in the cycle after the clock in which `pre_tick` ended the last (M-th) prescaler period.
- R4: `ref_pulse` is high for one clock after every R-th `xtal_tick`, so that R crystal ticks separate consecutive pulses.
- R5: Values written with `cfg_wr` leave the output cycle in progress untouched. The first full cycle after the next terminal count uses them.
- R6: A write is rejected when M = 0, M < A or R = 0. A rejected write sets `cfg_err`, and the previous M, A and R stay in force. An accepted write clears `cfg_err`.
- R7: Reset gives `fb_pulse` = 0, `ref_pulse` = 0, `cfg_err` = 0, and starts a cycle with the default ratio DEF_MAIN = 4, DEF_SWALLOW = 2 (N = 130) and DEF_REF = 5. With these defaults, `mod_sel` is high in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock, one cycle per input tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_tick | input | 1 | One-cycle strobe at the end of each prescaler period |
| xtal_tick | input | 1 | One-cycle strobe per crystal period |
| cfg_wr | input | 1 | Write strobe for the three ratio fields |
| cfg_main | input | 11 | Main count M |
| cfg_swallow | input | 5 | Swallow count A |
| cfg_ref | input | 11 | Reference divide R |
| mod_sel | output | 1 | Modulus select: high selects divide-by-33 |
| fb_pulse | output | 1 | Divided feedback pulse toward the phase detector |
| ref_pulse | output | 1 | Divided reference pulse toward the phase detector |
| cfg_err | output | 1 | Last write was rejected |

## Verification
A wrong main or swallow count shows up as a feedback interval that differs from 32·M + A. This error is visible within the first output cycle after the fault. A swallow count that is off by k moves the interval by k ticks, while a main count error moves it by multiples of 32. The bench therefore measures each interval in oscillator ticks, and it also counts long prescaler periods through its behavioural prescaler. This separates a modulus-select fault from a main-count fault. Shadow-timing errors appear as the wrong value in the first interval after a write, and the reference path is checked the same way in crystal ticks.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  parameter int unsigned MAIN_W = 11;
  parameter int unsigned SWAL_W = 5;
  parameter int unsigned REFC_W = 11;

  typedef struct packed {
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swal_cnt;
    logic [REFC_W-1:0] refc_cnt;
  } ratio_t;

endpackage

// File: rtl/psd_rst_sync.sv
module psd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/psd_cfg_shadow.sv
module psd_cfg_shadow
  import pswallow_pkg::*;
#(
  parameter int unsigned DEF_MAIN    = 4,
  parameter int unsigned DEF_SWALLOW = 2,
  parameter int unsigned DEF_REF     = 5
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              cfg_wr,
  input  logic [MAIN_W-1:0] cfg_main,
  input  logic [SWAL_W-1:0] cfg_swallow,
  input  logic [REFC_W-1:0] cfg_ref,
  output ratio_t            shadow,
  output logic              cfg_err
);

  ratio_t shadow_q, shadow_d;
  logic   err_q, err_d;
  logic   wr_bad;

  always_comb begin
    wr_bad = (cfg_main == '0) || (cfg_ref == '0) ||
             ({{(MAIN_W > SWAL_W ? 1 : 0){1'b0}}, cfg_main} <
              {{(MAIN_W > SWAL_W ? MAIN_W - SWAL_W + 1 : 1){1'b0}}, cfg_swallow});
    shadow_d = shadow_q;
    err_d    = err_q;
    if (cfg_wr) begin
      if (wr_bad) begin
        err_d = 1'b1;
      end else begin
        err_d             = 1'b0;
        shadow_d.main_cnt = cfg_main;
        shadow_d.swal_cnt = cfg_swallow;
        shadow_d.refc_cnt = cfg_ref;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      shadow_q.main_cnt <= MAIN_W'(DEF_MAIN);
      shadow_q.swal_cnt <= SWAL_W'(DEF_SWALLOW);
      shadow_q.refc_cnt <= REFC_W'(DEF_REF);
      err_q             <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      err_q    <= err_d;
    end
  end

  assign shadow  = shadow_q;
  assign cfg_err = err_q;

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_wr && wr_bad) |=> (cfg_err && $stable(shadow_q))); // R6

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_wr && !wr_bad) |=> !cfg_err); // R6

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
  import pswallow_pkg::*;
#(
  parameter int unsigned DEF_MAIN    = 4,
  parameter int unsigned DEF_SWALLOW = 2
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              pre_tick,
  input  logic [MAIN_W-1:0] sh_main,
  input  logic [SWAL_W-1:0] sh_swal,
  output logic              mod_sel,
  output logic              fb_pulse
);

  logic [MAIN_W-1:0] main_left_q, main_left_d;
  logic [SWAL_W-1:0] swal_left_q, swal_left_d;
  logic              fb_q;
  logic              term_cnt;

  always_comb begin
    term_cnt    = pre_tick && (main_left_q == '0);
    main_left_d = main_left_q;
    swal_left_d = swal_left_q;
    if (term_cnt) begin
      main_left_d = sh_main - 1'b1;
      swal_left_d = sh_swal;
    end else if (pre_tick) begin
      main_left_d = main_left_q - 1'b1;
      if (swal_left_q != '0) swal_left_d = swal_left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      main_left_q <= MAIN_W'(DEF_MAIN - 1);
      swal_left_q <= SWAL_W'(DEF_SWALLOW);
      fb_q        <= 1'b0;
    end else begin
      main_left_q <= main_left_d;
      swal_left_q <= swal_left_d;
      fb_q        <= term_cnt;
    end
  end

  assign mod_sel  = (swal_left_q != '0);
  assign fb_pulse = fb_q;

  AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (!rst_ns)
    int'(swal_left_q) <= int'(main_left_q) + 1); // R2

  AST_FB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_ns)
    fb_pulse |-> $past(pre_tick)); // R3

  AST_FB_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !pre_tick |=> ($stable(main_left_q) && $stable(swal_left_q))); // R1

endmodule

// File: rtl/psd_ref_ctr.sv
module psd_ref_ctr
  import pswallow_pkg::*;
#(
  parameter int unsigned DEF_REF = 5
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              xtal_tick,
  input  logic [REFC_W-1:0] sh_ref,
  output logic              ref_pulse
);

  logic [REFC_W-1:0] ref_left_q, ref_left_d;
  logic              ref_q;
  logic              ref_tc;

  always_comb begin
    ref_tc     = xtal_tick && (ref_left_q == '0);
    ref_left_d = ref_left_q;
    if (ref_tc)         ref_left_d = sh_ref - 1'b1;
    else if (xtal_tick) ref_left_d = ref_left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ref_left_q <= REFC_W'(DEF_REF - 1);
      ref_q      <= 1'b0;
    end else begin
      ref_left_q <= ref_left_d;
      ref_q      <= ref_tc;
    end
  end

  assign ref_pulse = ref_q;

  AST_REF_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_ns)
    ref_pulse |-> $past(xtal_tick)); // R4

  AST_REF_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !xtal_tick |=> $stable(ref_left_q)); // R4

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import pswallow_pkg::*;
#(
  parameter int unsigned DEF_MAIN    = 4,
  parameter int unsigned DEF_SWALLOW = 2,
  parameter int unsigned DEF_REF     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_tick,
  input  logic              xtal_tick,
  input  logic              cfg_wr,
  input  logic [MAIN_W-1:0] cfg_main,
  input  logic [SWAL_W-1:0] cfg_swallow,
  input  logic [REFC_W-1:0] cfg_ref,
  output logic              mod_sel,
  output logic              fb_pulse,
  output logic              ref_pulse,
  output logic              cfg_err
);

  logic   rst_ns;
  ratio_t shadow;

  psd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  psd_cfg_shadow #(
    .DEF_MAIN    (DEF_MAIN),
    .DEF_SWALLOW (DEF_SWALLOW),
    .DEF_REF     (DEF_REF)
  ) u_cfg (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .cfg_wr      (cfg_wr),
    .cfg_main    (cfg_main),
    .cfg_swallow (cfg_swallow),
    .cfg_ref     (cfg_ref),
    .shadow      (shadow),
    .cfg_err     (cfg_err)
  );

  psd_swallow_ctr #(
    .DEF_MAIN    (DEF_MAIN),
    .DEF_SWALLOW (DEF_SWALLOW)
  ) u_swallow (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .pre_tick (pre_tick),
    .sh_main  (shadow.main_cnt),
    .sh_swal  (shadow.swal_cnt),
    .mod_sel  (mod_sel),
    .fb_pulse (fb_pulse)
  );

  psd_ref_ctr #(.DEF_REF(DEF_REF)) u_ref (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .xtal_tick (xtal_tick),
    .sh_ref    (shadow.refc_cnt),
    .ref_pulse (ref_pulse)
  );

endmodule

// File: tb/test_pswallow_divider.sv
module test_pswallow_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_tick = 1'b0;
  logic        xtal_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [10:0] cfg_main = '0;
  logic [4:0]  cfg_swallow = '0;
  logic [10:0] cfg_ref = '0;
  logic        mod_sel, fb_pulse, ref_pulse, cfg_err;

  int checks = 0;
  int fails  = 0;

  int tick_cnt = 0, long_cnt = 0, last_n = 0, last_long = 0, fb_count = 0;
  int r_ticks = 0, last_r = 0, ref_count = 0;
  int pre_left = 0, xt_div = 0;
  bit first = 1'b1, fb_prev = 1'b0, ref_prev = 1'b0;
  int cur_m = 4, cur_a = 2, cur_r = 5;

  always #5 clk = ~clk;

  pswallow_divider i_pswallow_divider (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .xtal_tick(xtal_tick),
    .cfg_wr(cfg_wr), .cfg_main(cfg_main), .cfg_swallow(cfg_swallow),
    .cfg_ref(cfg_ref), .mod_sel(mod_sel), .fb_pulse(fb_pulse),
    .ref_pulse(ref_pulse), .cfg_err(cfg_err)
  );

  function automatic int exp_n(int m, int a);
    return 32 * m + a;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural prescaler, crystal and measurement, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      first = 1'b1; pre_tick = 1'b0; xtal_tick = 1'b0; xt_div = 0;
      tick_cnt = 0; long_cnt = 0; r_ticks = 0;
    end else begin
      if (fb_pulse) begin
        check("R3 pulse width", int'(fb_prev), 0);
        last_n = tick_cnt; last_long = long_cnt;
        tick_cnt = 0; long_cnt = 0; fb_count++;
      end
      fb_prev = fb_pulse;
      tick_cnt++;
      if (first || pre_tick) begin
        pre_left = mod_sel ? 33 : 32;
        if (mod_sel) long_cnt++;
        first = 1'b0;
      end else begin
        pre_left--;
      end
      pre_tick = (pre_left == 1);
      if (ref_pulse) begin
        check("R4 pulse width", int'(ref_prev), 0);
        last_r = r_ticks; r_ticks = 0; ref_count++;
      end
      ref_prev = ref_pulse;
      if (xtal_tick) r_ticks++;
      xt_div = (xt_div == 2) ? 0 : xt_div + 1;
      xtal_tick = (xt_div == 0);
    end
  end

  task automatic wait_fb();
    int c0 = fb_count;
    wait (fb_count != c0);
  endtask

  task automatic wait_ref(int k);
    for (int i = 0; i < k; i++) begin
      int c0 = ref_count;
      wait (ref_count != c0);
    end
  endtask

  task automatic write_cfg(int m, int a, int r);
    @(negedge clk);
    cfg_main = 11'(m); cfg_swallow = 5'(a); cfg_ref = 11'(r); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // valid write right after a feedback pulse: old ratio finishes, new one follows
  task automatic apply(int m, int a, int r);
    wait_fb();
    write_cfg(m, a, r);
    wait_fb();
    check("R5 cycle in progress keeps old N", last_n, exp_n(cur_m, cur_a));
    cur_m = m; cur_a = a; cur_r = r;
    wait_fb();
    check("R1 ticks per output", last_n, exp_n(m, a));
    check("R2 long periods", last_long, a);
    check("R6 err cleared", int'(cfg_err), 0);
    wait_ref(3);
    check("R4 crystal ticks per ref", last_r, r);
  endtask

  task automatic reject(int m, int a, int r);
    wait_fb();
    write_cfg(m, a, r);
    check("R6 err set", int'(cfg_err), 1);
    wait_fb();
    wait_fb();
    check("R6 ratio held", last_n, exp_n(cur_m, cur_a));
    check("R6 long periods held", last_long, cur_a);
    wait_ref(3);
    check("R6 ref held", last_r, cur_r);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    check("R7 fb_pulse reset", int'(fb_pulse), 0);
    check("R7 ref_pulse reset", int'(ref_pulse), 0);
    check("R7 cfg_err reset", int'(cfg_err), 0);
    check("R7 mod_sel reset", int'(mod_sel), 1);
    rst_n = 1'b1;
    wait_fb();
    wait_fb();
    check("R7 default N", last_n, 130);
    check("R7 default long periods", last_long, 2);
    wait_ref(2);
    check("R7 default R", last_r, 5);

    apply(937, 16, 7);   // N = 30000
    apply(1, 0, 1);      // shortest cycle
    apply(1, 1, 2);      // all periods long
    apply(31, 31, 3);    // full swallow range
    apply(20, 0, 11);    // no swallow
    reject(3, 5, 4);     // M < A
    reject(0, 0, 4);     // M = 0
    reject(9, 2, 0);     // R = 0
    for (int i = 0; i < 6; i++) begin
      int m, a, r, amax;
      m    = int'($urandom % 40) + 1;
      amax = (m < 31) ? m : 31;
      a    = int'($urandom % (amax + 1));
      r    = int'($urandom % 30) + 1;
      apply(m, a, r);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule